// File: doc/BRIEF.md
# Constant Divide-by-53 Unit

This block divides an 8-bit unsigned operand by the fixed constant 53. It produces a 3-bit quotient and a 6-bit remainder. It does not use a division operator. A small controller accepts one operand when the unit is idle. After that, each clock performs at most one compare-and-subtract on a working copy of the operand and counts the subtractions. When the working value is below 53, the count becomes the quotient and the leftover becomes the remainder.

To use it, the host raises `start` for one cycle with the operand on `dividend`. It then waits for the one-cycle `done` pulse and reads `quotient` and `remainder` in that cycle or later. The results stay unchanged until the next completed division. The unit handles one operand at a time, and `busy` shows when it will refuse a new one. The output widths are the smallest that hold the largest results: quotient 4 and remainder 52.

Top module: `const_div53`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls (asynchronously), `busy`, `done`, `quotient` and `remainder` are all 0.
- R2: A `start` sampled high on a clock edge while `busy` is low latches `dividend`, and `busy` is high after that edge.
- R3: On `done`, `quotient` equals the integer part of dividend/53 and `remainder` equals dividend mod 53, for every 8-bit dividend. Examples: 108 gives 2 and 2, 20 gives 0 and 20, 255 gives 4 and 43.
- R4: Counting the accepting edge as edge 0, `done` rises and `busy` falls on edge quotient+1. The longest case is 5 edges, for dividends 212 to 255. `busy` ends only through `done`.
- R5: `done` is high for exactly one cycle per accepted operand.
- R6: A `start` sampled while `busy` is high is ignored. The result and the latency are those of the operand accepted earlier, whatever `dividend` carries.
- R7: `quotient` and `remainder` change only on the edge that raises `done`. They hold while the unit is idle and throughout the next division.
- R8: When `done` is high, `remainder` is below 53 and `quotient` is at most 4.
- R9: A `start` presented in the same cycle that `done` is high is accepted, so divisions may run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to divide `dividend`; taken only when idle |
| dividend | input | 8 | Unsigned operand |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results update |
| quotient | output | 3 | Integer quotient by 53 |
| remainder | output | 6 | Remainder after division by 53 |

## Verification
The bench sweeps all 256 dividends. For each one it checks the quotient, the remainder and the exact edge on which `done` rises. A loop that stops one step early or late shows up as a wrong remainder or a shifted pulse, most clearly at the boundaries 52, 53, 211, 212 and 255. Several runs drive `start` on every busy cycle with a different operand. A design that re-latches the operand, or restarts, returns that operand's result or stretches the latency. Back-to-back starts on the `done` cycle, checks that the old results hold during a new division, and a reset in mid-division together catch a result register that follows the working value, or a lost operand.

// File: rtl/div53_pkg.sv
package div53_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

  // Quotient of num by den, computed by subtraction at elaboration time.
  function automatic int quo_by_sub(input int num, input int den);
    int rest;
    int q;
    rest = num;
    q    = 0;
    while (rest >= den) begin
      rest = rest - den;
      q    = q + 1;
    end
    return q;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int bits_for(input int v);
    int b;
    b = 1;
    while ((1 << b) <= v) b = b + 1;
    return b;
  endfunction

endpackage

// File: rtl/div53_ctrl.sv
module div53_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic below,
  output logic accept,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  import div53_pkg::*;

  div_state_e state_q, state_d;
  logic       done_q;

  assign accept = start && (state_q == ST_IDLE);
  assign finish = (state_q == ST_RUN) && below;
  assign step   = (state_q == ST_RUN) && !below;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (below) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

endmodule

// File: rtl/div53_datapath.sv
module div53_datapath #(
  parameter int DW      = 8,
  parameter int DIVISOR = 53,
  parameter int QW      = 3,
  parameter int RW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dividend,
  input  logic          accept,
  input  logic          step,
  input  logic          finish,
  output logic          below,
  output logic [QW-1:0] quo,
  output logic [RW-1:0] rem
);
  localparam logic [DW-1:0] DIV_V = DW'(DIVISOR);

  logic [DW-1:0] work_q;
  logic [QW-1:0] cnt_q;
  logic [QW-1:0] quo_q;
  logic [RW-1:0] rem_q;

  // One subtraction step on the working value.
  function automatic logic [DW-1:0] sub_once(input logic [DW-1:0] w);
    return w - DIV_V;
  endfunction

  // Comparison that ends the loop.
  function automatic logic is_below(input logic [DW-1:0] w);
    return w < DIV_V;
  endfunction

  assign below = is_below(work_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      work_q <= dividend;
      cnt_q  <= '0;
    end else if (step) begin
      work_q <= sub_once(work_q);
      cnt_q  <= cnt_q + QW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (finish) begin
      quo_q <= cnt_q;
      rem_q <= work_q[RW-1:0];
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

endmodule

// File: rtl/const_div53.sv
module const_div53 #(
  parameter int  DW      = 8,
  parameter int  DIVISOR = 53,
  localparam int QMAX    = div53_pkg::quo_by_sub((1 << DW) - 1, DIVISOR),
  localparam int QW      = div53_pkg::bits_for(QMAX),
  localparam int RW      = div53_pkg::bits_for(DIVISOR - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic [RW-1:0] remainder
);

  // Internal events, named for the checker.
  logic accept;
  logic step;
  logic finish;
  logic below;

  div53_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .below  (below),
    .accept (accept),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  div53_datapath #(
    .DW      (DW),
    .DIVISOR (DIVISOR),
    .QW      (QW),
    .RW      (RW)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dividend (dividend),
    .accept   (accept),
    .step     (step),
    .finish   (finish),
    .below    (below),
    .quo      (quotient),
    .rem      (remainder)
  );

endmodule

// File: rtl/div53_chk.sv
module div53_chk #(
  parameter int DW      = 8,
  parameter int DIVISOR = 53,
  parameter int QW      = 3,
  parameter int RW      = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] dividend,
  input logic          busy,
  input logic          done,
  input logic [QW-1:0] quotient,
  input logic [RW-1:0] remainder,
  input logic          accept,
  input logic          step,
  input logic          finish
);
  localparam int QMAX = div53_pkg::quo_by_sub((1 << DW) - 1, DIVISOR);

  logic [DW-1:0] opnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opnd_q <= '0;
    else if (start && !busy) opnd_q <= dividend;
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((int'(quotient) * DIVISOR + int'(remainder)) == int'(opnd_q)));

  assert_busy_ends_by_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_finish_to_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  assert_step_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  assert_result_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((int'(remainder) < DIVISOR) && (int'(quotient) <= QMAX)));

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && !done));

endmodule

bind const_div53 div53_chk #(
  .DW      (DW),
  .DIVISOR (DIVISOR),
  .QW      (QW),
  .RW      (RW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dividend  (dividend),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .accept    (accept),
  .step      (step),
  .finish    (finish)
);

// File: tb/sim_const_div53.sv
`timescale 1ns/1ps
module sim_const_div53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic       busy;
  logic       done;
  logic [2:0] quotient;
  logic [5:0] remainder;

  int nchecks = 0;
  int nerr    = 0;
  int last_q  = 0;
  int last_r  = 0;

  always #10 clk = ~clk;  // 50 MHz

  const_div53 u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset_state(input string req);
    chk(busy == 1'b0, req, busy, 0);
    chk(done == 1'b0, req, done, 0);
    chk(quotient == 3'd0, req, quotient, 0);
    chk(remainder == 6'd0, req, remainder, 0);
  endtask

  // Starts a division at the current negedge; returns at the negedge where done is seen.
  task automatic run_op(input int x, input bit interfere);
    int  n;
    bit  got;
    int  eq;
    int  er;
    string rq;
    eq = 0;
    er = x;
    while (er >= 53) begin
      er = er - 53;
      eq = eq + 1;
    end
    rq = interfere ? "R6" : "R3";
    start    = 1'b1;
    dividend = 8'(x);
    @(negedge clk);
    chk(busy == 1'b1, "R2", busy, 1);
    chk(done == 1'b0, "R5", done, 0);
    chk(quotient == 3'(last_q), "R7", quotient, last_q);
    chk(remainder == 6'(last_r), "R7", remainder, last_r);
    if (interfere) dividend = 8'(~x);
    else start = 1'b0;
    n = 1;
    got = 1'b0;
    while (!got && n < 20) begin
      @(negedge clk);
      n++;
      if (done) got = 1'b1;
      else if (interfere) dividend = 8'(x + n * 37);
    end
    start = 1'b0;
    chk(got && (n - 1) == eq + 1, interfere ? "R6" : "R4", n - 1, eq + 1);
    chk(busy == 1'b0, "R4", busy, 0);
    chk(quotient == 3'(eq), rq, quotient, eq);
    chk(remainder == 6'(er), rq, remainder, er);
    chk(remainder < 6'd53 && quotient <= 3'd4, "R8", remainder, er);
    last_q = eq;
    last_r = er;
  endtask

  task automatic idle_gap();
    @(negedge clk);
    chk(done == 1'b0, "R5", done, 0);
    chk(busy == 1'b0, "R4", busy, 0);
    chk(quotient == 3'(last_q), "R7", quotient, last_q);
    chk(remainder == 6'(last_r), "R7", remainder, last_r);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    #1;
    chk_reset_state("R1");
    repeat (3) @(negedge clk);
    chk_reset_state("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // Named examples (R3): 108 -> 2/2, 20 -> 0/20, 255 -> 4/43.
    run_op(108, 1'b0); idle_gap();
    run_op(20, 1'b0);  idle_gap();
    run_op(255, 1'b0); idle_gap();

    // Full sweep of the operand range (R3, R4, R8).
    for (int x = 0; x < 256; x++) begin
      run_op(x, 1'b0);
      idle_gap();
    end

    // Start held on every busy cycle with other operands (R6).
    run_op(255, 1'b1); idle_gap();
    run_op(53, 1'b1);  idle_gap();
    run_op(52, 1'b1);  idle_gap();
    run_op(0, 1'b1);   idle_gap();
    run_op(212, 1'b1); idle_gap();

    // Back-to-back: new start on the done cycle (R9).
    run_op(200, 1'b0);
    run_op(7, 1'b0);
    run_op(159, 1'b0);
    idle_gap();
    repeat (5) idle_gap();

    // Asynchronous reset in mid-division (R1).
    start    = 1'b1;
    dividend = 8'd255;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset_state("R1");
    @(negedge clk);
    chk_reset_state("R1");
    rst_n  = 1'b1;
    last_q = 0;
    last_r = 0;
    @(negedge clk);
    chk_reset_state("R1");
    run_op(106, 1'b0);
    idle_gap();

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule